// File: doc/BRIEF.md
# External Pin Reset Sequencer

This block runs on the always-on slow clock and watches an active-low reset pin that both outside devices and the block itself may pull low. When pin reset is enabled and the pin is seen low, the block asserts the processor and peripheral resets at once. It stops the processor clock and pulls the pin low itself for a programmable stretch. It then waits until the pin reads high again, restarts the processor clock, and counts a short startup interval before it releases both resets.

A status field records what caused the most recent reset. The field is written with the pin-reset code when the processor reset releases, and with the backup code when a backup-wake request arrives. It holds its value between those events. The pin is modelled as wired-AND: the pin reads low whenever the outside holds it low or the block's pull-down is active.

Top module: `pin_reset_seq`

## Requirements
- R1: The raw pin passes through a two-stage synchronizer reset to high. A low pin level sampled at clock edge k asserts the resets right after edge k+2. A low level present for a single edge is enough to start the sequence.
- R2: With `usr_rst_en` at 0 in idle, a low pin never starts the sequence, and `proc_rst` stays 0.
- R3: `proc_rst` and `periph_rst` assert on the same cycle and release on the same cycle.
- R4: The length field `ext_len` is captured when the sequence starts. `pin_pull_low` is 1 for exactly 2^(ext_len+1) consecutive cycles, starting with the cycle the resets assert. `ext_len` is 4 bits, so the maximum stretch is 65536 cycles.
- R5: After the stretch has elapsed, both resets stay asserted and the processor clock stays stopped for as long as the synchronized pin reads low.
- R6: `proc_clk_en` is 0 from the start of the sequence until the synchronized pin reads high after the stretch. A pin that rises at edge k gives `proc_clk_en` = 1 after edge k+3. Both resets release 3 cycles after `proc_clk_en` rises.
- R7: On the edge where the resets release, `rst_cause` is loaded with 4 (pin reset).
- R8: A `bkup_req` sampled high at an edge loads `rst_cause` with 1 (backup reset). A backup request on the same edge as a reset release takes priority over the pin-reset code. At all other edges `rst_cause` keeps its value.
- R9: While `por_n` is low: `proc_rst`, `periph_rst` and `pin_pull_low` are 0, `proc_clk_en` is 1 and `rst_cause` is 0.
- R10: Dropping `usr_rst_en` after the sequence has started does not abort it. The sequence completes and records cause 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| por_n | input | 1 | Power-on reset of the block's own state, active low, asynchronous |
| pin_n_raw | input | 1 | Raw level of the external reset pin, asynchronous |
| usr_rst_en | input | 1 | 1 lets a low pin start a reset sequence |
| ext_len | input | 4 | Stretch length code; the pull-down lasts 2^(ext_len+1) cycles |
| bkup_req | input | 1 | Backup-wake reset indication, one cycle per event |
| proc_rst | output | 1 | Processor reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| pin_pull_low | output | 1 | Enables the pin pull-down |
| proc_clk_en | output | 1 | Processor clock enable |
| rst_cause | output | 3 | Cause of last reset: 0 none, 1 backup, 4 pin |

## Verification
The hardest case to reach is the processor clock and both resets held past the stretch by an outside driver. The pin is already low from the block's own pull-down, so a test that only watches for assertion cannot show the extension. The bench models the pin as the AND of an external driver and the inverted pull-down. It holds the external driver low well past a short stretch, then checks cycle by cycle that the block waits for the synchronized high level. A second hard case is a backup request on exactly the release edge. The stimulus reaches it by counting edges from the rise of the clock enable.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
   localparam int CAUSE_W = 3;
   localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 3'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_BACKUP = 3'd1;
   localparam logic [CAUSE_W-1:0] CAUSE_PIN    = 3'd4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_START = 2'd2
   } seq_state_e;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rst_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rst_stretch_cnt.sv
module rst_stretch_cnt #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             busy
);
   if (LEN_W < 1 || LEN_W > 5) begin : g_bad_len
      $error("rst_stretch_cnt: LEN_W must lie in 1..5");
   end

   localparam int CNT_W = (1 << LEN_W) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W:0]   shift_amt;

   assign shift_amt = {1'b0, len} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= CNT_W'(1) << shift_amt;
      else if (busy)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = |cnt_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_seq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_pin,
   input  logic               set_backup,
   output logic [CAUSE_W-1:0] cause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cause <= CAUSE_NONE;
      else if (set_backup) cause <= CAUSE_BACKUP;
      else if (set_pin)    cause <= CAUSE_PIN;
   end
endmodule

// File: rtl/pin_reset_seq.sv
module pin_reset_seq
   import rst_seq_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int STARTUP_CYCLES = 3,
   parameter int LEN_W          = 4
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               pin_n_raw,
   input  logic               usr_rst_en,
   input  logic [LEN_W-1:0]   ext_len,
   input  logic               bkup_req,
   output logic               proc_rst,
   output logic               periph_rst,
   output logic               pin_pull_low,
   output logic               proc_clk_en,
   output logic [CAUSE_W-1:0] rst_cause
);
   if (STARTUP_CYCLES < 2) begin : g_bad_startup
      $error("pin_reset_seq: STARTUP_CYCLES must be at least 2");
   end

   localparam int SU_W = $clog2(STARTUP_CYCLES);
   localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

   seq_state_e      st_q, st_d;
   logic [SU_W-1:0] su_q, su_d;
   logic            pin_s;
   logic            stretch_busy;
   logic            load_stretch;
   logic            release_now;

   rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (por_n),
      .pin_async (pin_n_raw),
      .pin_sync  (pin_s)
   );

   rst_stretch_cnt #(.LEN_W(LEN_W)) u_stretch (
      .clk   (clk),
      .rst_n (por_n),
      .load  (load_stretch),
      .len   (ext_len),
      .busy  (stretch_busy)
   );

   rst_cause_reg u_cause (
      .clk        (clk),
      .rst_n      (por_n),
      .set_pin    (release_now),
      .set_backup (bkup_req),
      .cause      (rst_cause)
   );

   always_comb begin
      st_d         = st_q;
      su_d         = su_q;
      load_stretch = 1'b0;
      release_now  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (usr_rst_en && !pin_s) begin
               st_d         = ST_HOLD;
               load_stretch = 1'b1;
            end
         end
         ST_HOLD: begin
            if (!stretch_busy && pin_s) begin
               st_d = ST_START;
               su_d = '0;
            end
         end
         ST_START: begin
            if (su_q == SU_LAST) begin
               st_d        = ST_IDLE;
               release_now = 1'b1;
            end else begin
               su_d = su_q + 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q <= ST_IDLE;
         su_q <= '0;
      end else begin
         st_q <= st_d;
         su_q <= su_d;
      end
   end

   assign proc_rst     = (st_q != ST_IDLE);
   assign periph_rst   = (st_q != ST_IDLE);
   assign proc_clk_en  = (st_q != ST_HOLD);
   assign pin_pull_low = (st_q == ST_HOLD) && stretch_busy;
endmodule

// File: rtl/pin_reset_seq_chk.sv
module pin_reset_seq_chk
   import rst_seq_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               usr_rst_en,
   input logic               bkup_req,
   input logic               proc_rst,
   input logic               periph_rst,
   input logic               pin_pull_low,
   input logic               proc_clk_en,
   input logic [CAUSE_W-1:0] rst_cause,
   input logic               pin_s,
   input logic               busy
);
   AST_RESETS_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proc_rst) |-> $rose(periph_rst)); // R3
   AST_ENABLE_GATES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!usr_rst_en && !proc_rst) |=> !proc_rst); // R2
   AST_STRETCH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> proc_rst); // R4
   AST_PULL_ONLY_CLOCK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pull_low |-> !proc_clk_en); // R4
   AST_CLOCK_STOPPED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_clk_en |-> (proc_rst && periph_rst)); // R6
   AST_HOLD_WHILE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_clk_en && !pin_s) |=> (!proc_clk_en && proc_rst)); // R5
   AST_PIN_CAUSE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(proc_rst) && !$past(bkup_req)) |-> (rst_cause == CAUSE_PIN)); // R7
   AST_BACKUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bkup_req)) |-> (rst_cause == CAUSE_BACKUP)); // R8
   AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(rst_cause)) |-> ($fell(proc_rst) || $past(bkup_req))); // R8
endmodule

bind pin_reset_seq pin_reset_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (por_n),
   .usr_rst_en   (usr_rst_en),
   .bkup_req     (bkup_req),
   .proc_rst     (proc_rst),
   .periph_rst   (periph_rst),
   .pin_pull_low (pin_pull_low),
   .proc_clk_en  (proc_clk_en),
   .rst_cause    (rst_cause),
   .pin_s        (pin_s),
   .busy         (stretch_busy)
);

// File: tb/pin_reset_seq_tb_top.sv
`timescale 1ns/1ps
module pin_reset_seq_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_low = 1'b0;
   logic       usr_rst_en = 1'b0;
   logic [3:0] ext_len = 4'd0;
   logic       bkup_req = 1'b0;
   logic       run_cmp = 1'b0;
   logic       proc_rst, periph_rst, pin_pull_low, proc_clk_en;
   logic [2:0] rst_cause;
   wire        pin_n_raw = ext_low ? 1'b0 : ~pin_pull_low;
   int         n_chk = 0;
   int         n_err = 0;

   always #10 clk = ~clk;

   pin_reset_seq dut_i (
      .clk(clk), .por_n(por_n), .pin_n_raw(pin_n_raw), .usr_rst_en(usr_rst_en),
      .ext_len(ext_len), .bkup_req(bkup_req), .proc_rst(proc_rst),
      .periph_rst(periph_rst), .pin_pull_low(pin_pull_low),
      .proc_clk_en(proc_clk_en), .rst_cause(rst_cause)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // Behavioural reference: phase 0 idle, 1 pin held, 2 startup count
   bit sync_q[$] = '{1'b1, 1'b1};
   int m_phase = 0;
   int m_left = 0;
   int m_su = 0;
   int m_cause = 0;

   function automatic bit m_pull();
      return (m_phase == 1) && (m_left > 0);
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sync_q = '{1'b1, 1'b1};
         m_phase = 0; m_left = 0; m_su = 0; m_cause = 0;
      end else begin
         bit seen;
         bit pin_now;
         seen = sync_q[1];
         pin_now = ext_low ? 1'b0 : !m_pull();
         sync_q.push_front(pin_now);
         void'(sync_q.pop_back());
         case (m_phase)
            0: if (usr_rst_en && !seen) begin m_phase = 1; m_left = 1 << (int'(ext_len) + 1); end
            1: if (m_left > 0) m_left--; else if (seen) begin m_phase = 2; m_su = 0; end
            default: if (m_su == 2) begin m_phase = 0; m_cause = 4; end else m_su++;
         endcase
         if (bkup_req) m_cause = 1;
      end
   end

   always @(negedge clk) begin
      if (por_n && run_cmp) begin
         chk(proc_rst == (m_phase != 0), "R5 proc_rst", proc_rst, m_phase != 0);
         chk(periph_rst == (m_phase != 0), "R3 periph_rst", periph_rst, m_phase != 0);
         chk(pin_pull_low == m_pull(), "R4 pin_pull_low", pin_pull_low, m_pull());
         chk(proc_clk_en == (m_phase != 1), "R6 proc_clk_en", proc_clk_en, m_phase != 1);
         chk(rst_cause == 3'(m_cause), "R7 rst_cause", rst_cause, m_cause);
      end
   end

   // Runs one pin reset; ext driver held low for hold_extra cycles beyond detection
   task automatic pin_reset(input logic [3:0] len, input int hold_extra);
      int n;
      ext_len = len;
      ext_low = 1'b1;
      n = 0;
      while (!proc_rst) begin @(negedge clk); n++; end
      chk(n == 3, "R1 assert latency", n, 3);
      if (hold_extra == 0) ext_low = 1'b0;
      n = 0;
      while (pin_pull_low) begin @(negedge clk); n++; end
      chk(n == (1 << (int'(len) + 1)), "R4 stretch length", n, 1 << (int'(len) + 1));
      if (hold_extra > 0) begin
         repeat (hold_extra) begin
            @(negedge clk);
            chk(proc_rst && !proc_clk_en, "R5 held by pin", proc_rst, 1);
         end
         ext_low = 1'b0;
         n = 0;
         while (!proc_clk_en) begin @(negedge clk); n++; end
         chk(n == 3, "R6 clock restart", n, 3);
      end else begin
         while (!proc_clk_en) @(negedge clk);
      end
      n = 0;
      while (proc_rst) begin @(negedge clk); n++; end
      chk(n == 3, "R6 startup count", n, 3);
      chk(rst_cause == 3'd4, "R7 pin cause", rst_cause, 4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk(!proc_rst && !periph_rst, "R9 resets idle", proc_rst, 0);
      chk(!pin_pull_low, "R9 pull idle", pin_pull_low, 0);
      chk(proc_clk_en, "R9 clock on", proc_clk_en, 1);
      chk(rst_cause == 3'd0, "R9 cause clear", rst_cause, 0);
      por_n = 1'b1;
      run_cmp = 1'b1;
      repeat (3) @(negedge clk);

      // R2: disabled pin reset
      ext_low = 1'b1;
      repeat (8) @(negedge clk);
      chk(!proc_rst, "R2 disabled", proc_rst, 0);
      ext_low = 1'b0;
      repeat (4) @(negedge clk);

      usr_rst_en = 1'b1;
      pin_reset(4'd0, 0);
      repeat (5) @(negedge clk);
      pin_reset(4'd1, 0);
      repeat (5) @(negedge clk);
      pin_reset(4'd1, 25);
      repeat (5) @(negedge clk);

      // R8: backup request while idle, then held
      bkup_req = 1'b1;
      @(negedge clk);
      bkup_req = 1'b0;
      chk(rst_cause == 3'd1, "R8 backup code", rst_cause, 1);
      repeat (6) @(negedge clk);
      chk(rst_cause == 3'd1, "R8 cause held", rst_cause, 1);

      // R1: single-cycle low pulse starts a sequence
      ext_len = 4'd0;
      ext_low = 1'b1;
      @(negedge clk);
      ext_low = 1'b0;
      n = 0;
      while (!proc_rst && n < 6) begin @(negedge clk); n++; end
      chk(proc_rst, "R1 one-cycle pulse", proc_rst, 1);
      while (proc_rst) @(negedge clk);

      // R8: backup request on the release edge wins
      repeat (3) @(negedge clk);
      ext_low = 1'b1;
      while (!proc_rst) @(negedge clk);
      ext_low = 1'b0;
      while (!proc_clk_en || pin_pull_low) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      bkup_req = 1'b1;
      @(negedge clk);
      bkup_req = 1'b0;
      chk(!proc_rst, "R8 release edge", proc_rst, 0);
      chk(rst_cause == 3'd1, "R8 backup priority", rst_cause, 1);
      repeat (4) @(negedge clk);

      // R10: enable dropped mid-sequence
      ext_len = 4'd2;
      ext_low = 1'b1;
      while (!proc_rst) @(negedge clk);
      ext_low = 1'b0;
      usr_rst_en = 1'b0;
      n = 0;
      while (proc_rst && n < 40) begin @(negedge clk); n++; end
      chk(!proc_rst, "R10 completes", proc_rst, 0);
      chk(rst_cause == 3'd4, "R10 cause", rst_cause, 4);
      usr_rst_en = 1'b1;
      repeat (4) @(negedge clk);

      // R4: longest stretch
      pin_reset(4'd15, 0);
      repeat (4) @(negedge clk);
      run_cmp = 1'b0;
      finish_run();
   end
endmodule